// File: doc/BRIEF.md
# Pixel Unpacker with Color Palette Lookup

This block turns a stream of 64-bit packed words into a stream of 16-bit colors, one per clock. A depth code picks 1, 2, 4, 8 or 16 bits per pixel. The block takes pixels out of each held word starting at the least significant bits. At depths up to 8 bits, each pixel value is an index into an internal color table of up to 256 entries. At 16 bits, the pixel is the color itself and goes straight to the output. A flag on the output shows which of the two paths produced the color.

The color table is loaded over the same 64-bit input stream. A start pulse with an entry count opens a load phase. Each word accepted during that phase fills four table entries in turn, beginning at entry 0. The phase ends once the requested number of entries has been written, and later words are treated as pixel data again. A load request made while the depth code selects 16-bit pixels is rejected and raises an error pulse.

Colors use a 5-6-5 layout, with red in the top bits. When the monochrome option is on, only the low byte of a table entry is meaningful. Input words are accepted through a ready/valid handshake. A new word is taken only after the last pixel of the word being held has been issued.

Top module: `pix_unpack_pal`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and load_err is 0.
- R2: Depth code 0, 1, 2, 3 and 4 selects 1, 2, 4, 8 and 16 bits per pixel. That gives 64, 32, 16, 8 and 4 pixels per word. Pixel i of a word occupies bits [i*bpp+bpp-1 : i*bpp], and pixels leave in order of increasing i.
- R3: At depth codes 0 to 3, out_color equals the table entry addressed by the pixel value, and out_bypass is 0.
- R4: The table address equals the pixel value, so 1-bit pixels reach only entries 0 and 1, 2-bit pixels entries 0 to 3, 4-bit pixels entries 0 to 15, and 8-bit pixels all 256 entries.
- R5: At depth code 4, out_color equals the 16-bit pixel itself and out_bypass is 1.
- R6: When cfg_mono is 1, a color taken from the table has bits [15:8] forced to 0. Its bits [7:0] are the entry's low byte.
- R7: A pulse on load_start with load_count N (1 to 256), at depth codes 0 to 3, makes the next ceil(N/4) accepted words load the table. Bits [16k+15:16k] of the j-th load word go to entry 4j+k, but only while 4j+k < N. If N is 0, no load phase starts. Words after the load phase are pixel data.
- R8: A pulse on load_start at depth code 4 sets load_err to 1 for exactly the following cycle. It starts no load phase, leaves the table unchanged, and the following words are handled as pixels.
- R9: If a word is accepted at clock edge k, its first color appears with out_valid after edge k+1. Words supplied back to back give one valid color every cycle, with no gap.
- R10: During a load phase in_ready is 1. Otherwise in_ready is 1 only when no word is held or when the last pixel of the held word is being issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_depth | input | 3 | Pixel depth code (0 to 4 gives 1 to 16 bits) |
| cfg_mono | input | 1 | Monochrome option: colors from the table keep only their low byte |
| load_start | input | 1 | Pulse that opens a table load phase |
| load_count | input | 9 | Number of table entries to load |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted this cycle when high together with in_valid |
| in_data | input | 64 | Packed pixel word or table load word |
| out_valid | output | 1 | Output color valid |
| out_color | output | 16 | 5-6-5 color |
| out_bypass | output | 1 | 1 when the color bypassed the table |
| load_err | output | 1 | One-cycle pulse for a load request at 16-bit depth |

## Verification
The bench builds the block with its default parameters: 64-bit words, 16-bit colors and an 8-bit table address. This gives a full 256-entry table, every depth from 1 to 16 bits, and four table words per load word. The bench fills the whole table and then streams pixel data at every depth. It also covers:
- a partial load whose count is not a multiple of four, followed by reads of the untouched entries beside it;
- a zero-count load;
- a rejected load at 16-bit depth;
- exact first-output latency, and gapless back-to-back flow.

// File: rtl/pup_pkg.sv
package pup_pkg;
   localparam int DEPTH_CODE_W = 3;
   typedef logic [DEPTH_CODE_W-1:0] depth_code_t;

   // Codes beyond the widest depth behave as the widest depth
   function automatic depth_code_t clamp_depth(input depth_code_t code, input int max_log);
      if (int'(code) > max_log) return depth_code_t'(max_log);
      return code;
   endfunction
endpackage

// File: rtl/pup_slicer.sv
module pup_slicer
   import pup_pkg::*;
#(
   parameter int DATA_W  = 64,
   parameter int COLOR_W = 16,
   parameter int PAL_AW  = 8,
   localparam int IDX_W   = $clog2(DATA_W),
   localparam int LOG_MAX = $clog2(COLOR_W)
) (
   input  logic [DATA_W-1:0]  entry,
   input  logic [IDX_W-1:0]   pix_idx,
   input  depth_code_t        eff_depth,
   output logic [COLOR_W-1:0] pix_val,
   output logic [PAL_AW-1:0]  pal_idx,
   output logic [IDX_W-1:0]   last_idx
);
   logic [COLOR_W-1:0] cand [LOG_MAX+1];

   for (genvar d = 0; d <= LOG_MAX; d++) begin : g_depth
      localparam int BPP = 1 << d;
      logic [IDX_W-1:0]  shamt;
      logic [DATA_W-1:0] shifted;
      assign shamt   = pix_idx << d;
      assign shifted = entry >> shamt;
      assign cand[d] = COLOR_W'(shifted[BPP-1:0]);
   end

   assign pix_val  = cand[eff_depth];
   assign pal_idx  = pix_val[PAL_AW-1:0];
   assign last_idx = IDX_W'((DATA_W >> eff_depth) - 1);
endmodule

// File: rtl/pup_loader.sv
module pup_loader #(
   parameter int PAL_AW = 8,
   parameter int WORDS  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_start,
   input  logic [PAL_AW:0]    load_count,
   input  logic               bypass_mode,
   input  logic               wr_fire,
   output logic               loading,
   output logic               load_err,
   output logic [PAL_AW-1:0]  wr_base,
   output logic [WORDS-1:0]   wr_mask
);
   logic [PAL_AW:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loading  <= 1'b0;
         load_err <= 1'b0;
         wr_base  <= '0;
         remain   <= '0;
      end else begin
         load_err <= load_start && bypass_mode;
         if (load_start) begin
            if (!bypass_mode && load_count != '0) begin
               loading <= 1'b1;
               wr_base <= '0;
               remain  <= load_count;
            end
         end else if (loading && wr_fire) begin
            wr_base <= wr_base + PAL_AW'(WORDS);
            if (remain > (PAL_AW+1)'(WORDS)) begin
               remain <= remain - (PAL_AW+1)'(WORDS);
            end else begin
               remain  <= '0;
               loading <= 1'b0;
            end
         end
      end
   end

   for (genvar w = 0; w < WORDS; w++) begin : g_lane
      assign wr_mask[w] = loading && wr_fire && (remain > (PAL_AW+1)'(w));
   end
endmodule

// File: rtl/pup_palette.sv
module pup_palette #(
   parameter int COLOR_W = 16,
   parameter int PAL_AW  = 8,
   parameter int WORDS   = 4,
   localparam int DEPTH  = 1 << PAL_AW
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [WORDS-1:0]         wr_mask,
   input  logic [PAL_AW-1:0]        wr_base,
   input  logic [WORDS*COLOR_W-1:0] wr_data,
   input  logic                     rd_en,
   input  logic [PAL_AW-1:0]        rd_addr,
   output logic [COLOR_W-1:0]       rd_data
);
   logic [COLOR_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      for (int w = 0; w < WORDS; w++) begin
         if (wr_mask[w]) mem[wr_base + PAL_AW'(w)] <= wr_data[w*COLOR_W +: COLOR_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= mem[rd_addr];
   end
endmodule

// File: rtl/pix_unpack_pal.sv
module pix_unpack_pal
   import pup_pkg::*;
#(
   parameter int DATA_W  = 64,
   parameter int COLOR_W = 16,
   parameter int PAL_AW  = 8,
   localparam int IDX_W   = $clog2(DATA_W),
   localparam int LOG_MAX = $clog2(COLOR_W),
   localparam int WORDS   = DATA_W / COLOR_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2:0]          cfg_depth,
   input  logic                cfg_mono,
   input  logic                load_start,
   input  logic [PAL_AW:0]     load_count,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [DATA_W-1:0]   in_data,
   output logic                out_valid,
   output logic [COLOR_W-1:0]  out_color,
   output logic                out_bypass,
   output logic                load_err
);
   if (DATA_W % COLOR_W != 0) begin : g_bad_ratio
      $error("DATA_W must be a multiple of COLOR_W");
   end
   if ((1 << (LOG_MAX - 1)) > PAL_AW) begin : g_bad_aw
      $error("PAL_AW too small for the widest indexed depth");
   end
   if ((1 << LOG_MAX) != COLOR_W || LOG_MAX > 7) begin : g_bad_color
      $error("COLOR_W must be a power of two that fits the depth code");
   end

   depth_code_t         eff_depth;
   logic                bypass;
   logic                loading;
   logic [PAL_AW-1:0]   wr_base;
   logic [WORDS-1:0]    wr_mask;
   logic [DATA_W-1:0]   ent_q;
   logic                ent_v;
   logic [IDX_W-1:0]    pix_idx;
   logic [IDX_W-1:0]    last_idx;
   logic [COLOR_W-1:0]  pix_val;
   logic [PAL_AW-1:0]   pal_rd_addr;
   logic                pal_rd_en;
   logic [COLOR_W-1:0]  pal_rd_data;
   logic                is_last;
   logic                accept_pix;
   logic                byp_q;
   logic                mono_q;
   logic [COLOR_W-1:0]  byp_data_q;

   assign eff_depth  = clamp_depth(cfg_depth, LOG_MAX);
   assign bypass     = (int'(eff_depth) == LOG_MAX);
   assign is_last    = (pix_idx == last_idx);
   assign in_ready   = loading || !ent_v || is_last;
   assign accept_pix = in_valid && in_ready && !loading;
   assign pal_rd_en  = ent_v && !bypass;

   pup_loader #(.PAL_AW(PAL_AW), .WORDS(WORDS)) u_loader (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_start (load_start),
      .load_count (load_count),
      .bypass_mode(bypass),
      .wr_fire    (in_valid && loading),
      .loading    (loading),
      .load_err   (load_err),
      .wr_base    (wr_base),
      .wr_mask    (wr_mask)
   );

   pup_slicer #(.DATA_W(DATA_W), .COLOR_W(COLOR_W), .PAL_AW(PAL_AW)) u_slicer (
      .entry    (ent_q),
      .pix_idx  (pix_idx),
      .eff_depth(eff_depth),
      .pix_val  (pix_val),
      .pal_idx  (pal_rd_addr),
      .last_idx (last_idx)
   );

   pup_palette #(.COLOR_W(COLOR_W), .PAL_AW(PAL_AW), .WORDS(WORDS)) u_palette (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_mask(wr_mask),
      .wr_base(wr_base),
      .wr_data(in_data),
      .rd_en  (pal_rd_en),
      .rd_addr(pal_rd_addr),
      .rd_data(pal_rd_data)
   );

   // Held word and pixel position
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_q   <= '0;
         ent_v   <= 1'b0;
         pix_idx <= '0;
      end else if (accept_pix) begin
         ent_q   <= in_data;
         ent_v   <= 1'b1;
         pix_idx <= '0;
      end else if (ent_v) begin
         if (is_last) ent_v <= 1'b0;
         else         pix_idx <= pix_idx + 1'b1;
      end
   end

   // Bypass side delayed one cycle to line up with the table read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         byp_q      <= 1'b0;
         mono_q     <= 1'b0;
         byp_data_q <= '0;
      end else begin
         out_valid  <= ent_v;
         byp_q      <= bypass;
         mono_q     <= cfg_mono;
         byp_data_q <= pix_val;
      end
   end

   assign out_bypass = byp_q;
   assign out_color  = byp_q  ? byp_data_q :
                       mono_q ? {{(COLOR_W-8){1'b0}}, pal_rd_data[7:0]} : pal_rd_data;
endmodule

// File: rtl/pup_checker.sv
module pup_checker #(
   parameter int COLOR_W = 16,
   parameter int PAL_AW  = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [2:0]         cfg_depth,
   input logic               cfg_mono,
   input logic               load_start,
   input logic               load_err,
   input logic               in_ready,
   input logic               out_valid,
   input logic               out_bypass,
   input logic [COLOR_W-1:0] out_color,
   input logic               ent_v,
   input logic               loading,
   input logic               rd_en,
   input logic [PAL_AW-1:0]  rd_addr
);
   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && !load_err));

   assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load_err |-> ($past(load_start) && $past(cfg_depth) >= 3'd4));

   assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && cfg_depth < 3'd3) |-> ((rd_addr >> (4'd1 << cfg_depth)) == '0));

   assert_bypass_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_bypass == ($past(cfg_depth) >= 3'd4)));

   assert_mono_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_bypass && $past(cfg_mono)) |-> (out_color[COLOR_W-1:8] == '0));

   assert_load_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
      loading |-> in_ready);

   assert_out_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(ent_v));
endmodule

bind pix_unpack_pal pup_checker #(.COLOR_W(COLOR_W), .PAL_AW(PAL_AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_depth (cfg_depth),
   .cfg_mono  (cfg_mono),
   .load_start(load_start),
   .load_err  (load_err),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_bypass(out_bypass),
   .out_color (out_color),
   .ent_v     (ent_v),
   .loading   (loading),
   .rd_en     (pal_rd_en),
   .rd_addr   (pal_rd_addr)
);

// File: tb/pix_unpack_pal_tb.sv
module pix_unpack_pal_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cfg_depth = 3'd3;
   logic        cfg_mono = 1'b0;
   logic        load_start = 1'b0;
   logic [8:0]  load_count = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [63:0] in_data = '0;
   logic        out_valid;
   logic [15:0] out_color;
   logic        out_bypass;
   logic        load_err;

   int    errors = 0;
   int    checks = 0;
   string cur_req = "R1";
   bit    mon_en = 1'b0;
   bit    done = 1'b0;

   logic [15:0] mpal [256];
   logic [16:0] exp_q [$];
   bit          mload = 1'b0;
   int          maddr = 0;
   int          mrem = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pix_unpack_pal u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_mono(cfg_mono),
      .load_start(load_start), .load_count(load_count), .in_valid(in_valid),
      .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
      .out_color(out_color), .out_bypass(out_bypass), .load_err(load_err)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                      input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // Reference: what an accepted word means
   task automatic model_accept(input logic [63:0] d);
      if (mload) begin
         for (int k = 0; k < 4; k++) begin
            if (mrem > 0) begin
               mpal[maddr] = d[16*k +: 16];
               maddr++;
               mrem--;
            end
         end
         if (mrem == 0) mload = 1'b0;
      end else begin
         int bpp;
         bpp = 1 << cfg_depth;
         for (int i = 0; i < 64 / bpp; i++) begin
            logic [63:0] v;
            v = (d >> (i * bpp)) & ((64'd1 << bpp) - 64'd1);
            if (cfg_depth == 3'd4) exp_q.push_back({1'b1, v[15:0]});
            else begin
               logic [15:0] c;
               c = mpal[v[7:0]];
               if (cfg_mono) c = {8'h00, c[7:0]};
               exp_q.push_back({1'b0, c});
            end
         end
      end
   endtask

   task automatic send(input logic [63:0] d);
      in_valid = 1'b1;
      in_data  = d;
      while (!in_ready) @(negedge clk);
      model_accept(d);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic do_load(input int count);
      load_start = 1'b1;
      load_count = 9'(count);
      if (cfg_depth != 3'd4 && count != 0) begin
         mload = 1'b1; maddr = 0; mrem = count;
      end
      @(negedge clk);
      load_start = 1'b0;
      chk("R8", 32'(load_err), 32'(cfg_depth == 3'd4), "load_err after request");
      if (mload) chk("R10", 32'(in_ready), 1, "in_ready during load");
      @(negedge clk);
      chk("R8", 32'(load_err), 0, "load_err one cycle only");
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   function automatic logic [63:0] rnd64();
      return {$urandom(), $urandom()};
   endfunction

   // Output comparison on every clock
   always @(negedge clk) begin
      if (rst_n && mon_en) begin
         if (out_valid) begin
            if (exp_q.size() == 0) chk(cur_req, 1, 0, "unexpected out_valid");
            else begin
               logic [16:0] e;
               e = exp_q.pop_front();
               chk(cur_req, 32'({out_bypass, out_color}), 32'(e), "bypass flag and color");
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R9 watchdog: actual=hung expected=finished");
         report();
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) mpal[i] = '0;
      repeat (3) @(negedge clk);
      chk("R1", 32'(out_valid), 0, "out_valid in reset");
      chk("R1", 32'(load_err), 0, "load_err in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", 32'(in_ready), 1, "in_ready after reset");
      chk("R1", 32'(out_valid), 0, "out_valid after reset");
      mon_en = 1'b1;

      // Full table load at 8 bits
      cur_req = "R7";
      cfg_depth = 3'd3;
      do_load(256);
      for (int j = 0; j < 64; j++) send(rnd64());
      chk("R7", 32'(mload), 0, "model load finished");

      cur_req = "R3";
      for (int j = 0; j < 6; j++) send(rnd64());
      send(64'hFFFE_8001_7F80_0100);
      drain();

      // First output timing and held-word back-pressure
      cur_req = "R9";
      fork
         send(rnd64());
         begin
            @(negedge clk);
            chk("R9", 32'(out_valid), 0, "no output one cycle after accept");
            chk("R10", 32'(in_ready), 0, "in_ready low mid-word");
            @(negedge clk);
            chk("R9", 32'(out_valid), 1, "output two cycles after accept");
         end
      join
      drain();

      cur_req = "R2";
      cfg_depth = 3'd0;
      send(64'hA5A5_0F0F_1234_FFFF);
      send(rnd64());
      drain();
      cur_req = "R4";
      cfg_depth = 3'd1;
      send(64'h1B1B_E4E4_0000_FFFF);
      send(rnd64());
      drain();
      cfg_depth = 3'd2;
      send(64'hFEDC_BA98_7654_3210);
      send(rnd64());
      drain();

      cur_req = "R6";
      cfg_depth = 3'd3;
      cfg_mono = 1'b1;
      for (int j = 0; j < 3; j++) send(rnd64());
      drain();
      cfg_mono = 1'b0;

      cur_req = "R5";
      cfg_depth = 3'd4;
      for (int j = 0; j < 3; j++) send(rnd64());
      drain();
      cur_req = "R9";
      fork
         begin
            send(rnd64()); send(rnd64()); send(rnd64());
         end
         begin
            int seen;
            seen = 0;
            repeat (2) @(negedge clk);
            for (int c = 0; c < 12; c++) begin
               if (out_valid) seen++;
               @(negedge clk);
            end
            chk("R9", 32'(seen), 12, "gapless valid cycles for three words");
            chk("R9", 32'(out_valid), 0, "valid ends after last pixel");
         end
      join
      drain();

      // Rejected load at 16 bits
      cur_req = "R8";
      do_load(8);
      send(64'h0123_4567_89AB_CDEF);
      send(rnd64());
      drain();
      cfg_depth = 3'd3;
      send(64'h0706_0504_0302_0100);
      drain();

      // Partial and empty loads at 4 bits
      cur_req = "R7";
      cfg_depth = 3'd2;
      do_load(6);
      send(64'h1111_2222_3333_4444);
      send(64'h5555_6666_7777_8888);
      chk("R7", 32'(mload), 0, "model partial load finished");
      send(64'hFEDC_BA98_7654_3210);
      drain();
      do_load(0);
      send(64'h0123_4567_89AB_CDEF);
      drain();

      chk("R2", 32'(exp_q.size()), 0, "all expected colors seen");
      done = 1'b1;
      report();
   end
endmodule